// File: doc/BRIEF.md
# Triple Interval Timer with Read-Clear Tick Counters

This block holds three independent interval timers that a processor polls through a small register bus. A shared base tick drives all three. Each timer first divides that base tick by its own prescale factor. The result clocks an 8-bit divider that runs up to a programmable period. Every time the divider completes a period, a 4-bit tick counter advances.

Software gives each timer its period through a target register and switches timers on and off through bits of a control register. It reads elapsed periods from the tick counters. A counter read returns the value and empties the counter, so successive polls return only the periods that completed since the previous poll. Timers 0 and 1 use the slow prescale factor and timer 2 uses the fast one; both factors are parameters.

Top module: `interval_timers`

## Requirements
- R1: A target value N from 1 to 255 gives a period of N prescaled ticks, and a target of 0 gives a period of 256 prescaled ticks.
- R2: When the base tick is high in every cycle, a running timer advances its divider once every PRE cycles, where PRE is PRE_SLOW for timers 0 and 1 and PRE_FAST for timer 2. The tick counter increments when the divider completes a period, so after K clock edges since the enabling edge the counter holds floor(K / (PRE × period)) modulo 16.
- R3: The tick counter is 4 bits wide and wraps from 15 to 0.
- R4: When busRdEn is high with busAddr equal to 4+i, busRdData shows timer i's counter in the same cycle, and the counter becomes 0 at the following clock edge.
- R5: A bus write to address 4+i clears timer i's counter, whatever the data.
- R6: A write to address 0 that changes bit i from 0 to 1 resets timer i's prescaler, divider and counter to 0. A write that leaves bit i at 1 does not disturb the timer.
- R7: While a timer is disabled, its counter holds its value. A target written at address 1+i while timer i is disabled takes effect when the timer is next enabled.
- R8: Bits 0, 1 and 2 of the control register at address 0 enable timers 0, 1 and 2 independently. Reads of any address other than 4 to 6 return 0.
- R9: If a counter read or clear falls on the same edge as a period completion, the read returns the old value and the counter ends at 1.
- R10: After reset all timers are disabled, all targets are 0 and all counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | Base clock enable feeding all prescalers |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (clears the addressed counter) |
| busAddr | input | 3 | 0 control, 1..3 targets, 4..6 counters |
| busWrData | input | 8 | Write data |
| busRdData | output | 4 | Read data, combinational from the addressed counter |

## Verification
The assertions assume that read and write strobes are never high in the same cycle. They also assume that a target is never lowered below the current divider value while its timer runs, because in that case the divider would pass the period and wrap at 256 instead. The stimulus issues one bus access at a time from sequential tasks and rewrites targets only after writing 0 to the control register. The bench holds baseTick high and uses small prescale factors, so expected counts follow directly from the number of clock edges since the enabling write.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int TMR_COUNT = 3;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam int CNT_W     = 4;
  localparam int DIV_W     = 8;
  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_TGT_BASE = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT_BASE = 3'd4;

  typedef struct packed {
    logic enabled;
    logic restart;
    logic clearCnt;
    logic loadTarget;
  } tmrStrobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  busWrEn,
  input  logic                                  busRdEn,
  input  logic [ADDR_W-1:0]                     busAddr,
  input  logic [DATA_W-1:0]                     busWrData,
  input  logic [TMR_COUNT-1:0][CNT_W-1:0]       counts,
  output tmrStrobe_t [TMR_COUNT-1:0]            strobes,
  output logic [CNT_W-1:0]                      busRdData
);
  logic [TMR_COUNT-1:0] enReg;
  logic                 ctrlWrite;

  assign ctrlWrite = busWrEn && (busAddr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) enReg <= '0;
    else if (ctrlWrite) enReg <= busWrData[TMR_COUNT-1:0];
  end

  for (genvar i = 0; i < TMR_COUNT; i++) begin : g_strobe
    localparam logic [ADDR_W-1:0] TGT_ADDR = ADDR_TGT_BASE + ADDR_W'(i);
    localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_CNT_BASE + ADDR_W'(i);
    always_comb begin
      strobes[i].enabled    = enReg[i];
      strobes[i].restart    = ctrlWrite && busWrData[i] && !enReg[i];
      strobes[i].clearCnt   = (busRdEn || busWrEn) && (busAddr == CNT_ADDR);
      strobes[i].loadTarget = busWrEn && (busAddr == TGT_ADDR);
    end

    p_restart_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
      strobes[i].restart |-> !enReg[i]);
    p_restart_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
      strobes[i].restart |=> enReg[i]);
  end

  always_comb begin
    busRdData = '0;
    for (int i = 0; i < TMR_COUNT; i++)
      if (busAddr == ADDR_CNT_BASE + ADDR_W'(i)) busRdData = counts[i];
  end

  p_no_read_outside_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < ADDR_CNT_BASE) |-> (busRdData == '0));
endmodule

// File: rtl/timer_unit.sv
module timer_unit
  import timer_pkg::*;
#(
  parameter int PRESCALE = 128
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  tmrStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  count
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] preCnt;
  logic [DIV_W-1:0] divider;
  logic [DIV_W-1:0] target;
  logic [DIV_W:0]   period;
  logic             tick;
  logic             wrapDiv;

  assign period  = (target == '0) ? (DIV_W+1)'(1 << DIV_W) : {1'b0, target};
  assign tick    = strobe.enabled && baseTick && (preCnt == PRE_LAST);
  assign wrapDiv = tick && (({1'b0, divider} + 1'b1) == period);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      divider <= '0;
      target  <= '0;
      count   <= '0;
    end else begin
      if (strobe.loadTarget) target <= wrData;
      if (strobe.restart) begin
        preCnt  <= '0;
        divider <= '0;
        count   <= '0;
      end else begin
        if (strobe.enabled && baseTick) preCnt <= tick ? '0 : preCnt + 1'b1;
        if (tick) divider <= wrapDiv ? '0 : divider + 1'b1;
        count <= (strobe.clearCnt ? '0 : count) + CNT_W'(wrapDiv);
      end
    end
  end

  p_disabled_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.enabled && !strobe.restart && !strobe.clearCnt) |=> $stable(count));
  p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (count == '0 && divider == '0));
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restart && !strobe.clearCnt) |=>
      (count == $past(count) || count == $past(count) + 1'b1));
  p_clear_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearCnt && !strobe.restart) |=> (count <= CNT_W'(1)));
endmodule

// File: rtl/interval_timers.sv
module interval_timers
  import timer_pkg::*;
#(
  parameter int PRE_SLOW   = 128,
  parameter int PRE_FAST   = 16,
  parameter int FAST_INDEX = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [CNT_W-1:0]  busRdData
);
  tmrStrobe_t [TMR_COUNT-1:0]      strobes;
  logic [TMR_COUNT-1:0][CNT_W-1:0] counts;

  timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .counts(counts),
    .strobes(strobes), .busRdData(busRdData)
  );

  for (genvar i = 0; i < TMR_COUNT; i++) begin : g_tmr
    localparam int PRE = (i == FAST_INDEX) ? PRE_FAST : PRE_SLOW;
    timer_unit #(.PRESCALE(PRE)) u_unit (
      .clk(clk), .rstN(rstN), .baseTick(baseTick), .strobe(strobes[i]),
      .wrData(busWrData), .count(counts[i])
    );
  end
endmodule

// File: tb/interval_timers_bench.sv
module interval_timers_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // timer, target, wait, expected count = floor((wait+1)/(PRE*period)) % 16
  localparam int VEC_TMR [NVEC] = '{0, 1, 2, 2, 0, 1, 1, 2};
  localparam int VEC_TGT [NVEC] = '{3, 5, 1, 0, 1, 2, 2, 255};
  localparam int VEC_WT  [NVEC] = '{23, 59, 9, 1023, 71, 6, 7, 509};
  localparam int VEC_EXP [NVEC] = '{2, 3, 5, 2, 2, 0, 1, 1};

  logic clk = 0, rstN = 0, baseTick = 1, busWrEn = 0, busRdEn = 0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [3:0] busRdData;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timers #(.PRE_SLOW(4), .PRE_FAST(2), .FAST_INDEX(2)) u_interval_timers (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busWrite(int a, int d);
    @(negedge clk); busWrEn = 1; busAddr = 3'(a); busWrData = 8'(d);
    @(negedge clk); busWrEn = 0;
  endtask

  task automatic busRead(int a, output int v);
    @(negedge clk); busRdEn = 1; busAddr = 3'(a); #1 v = busRdData;
    @(negedge clk); busRdEn = 0;
  endtask

  task automatic startTimer(int t, int tgt);
    busWrite(0, 0);
    busWrite(1 + t, tgt);
    busWrite(0, 1 << t);
  endtask

  initial begin
    int v, v2;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10: reset state, and disabled timers stay at 0
    for (int t = 0; t < 3; t++) begin busRead(4 + t, v); check("R10 reset count", v, 0); end
    repeat (20) @(negedge clk);
    busRead(4, v); check("R7 disabled after reset", v, 0);
    busRead(0, v); check("R8 control address reads 0", v, 0);

    // table walk: R1 R2 R3
    for (int k = 0; k < NVEC; k++) begin
      startTimer(VEC_TMR[k], VEC_TGT[k]);
      repeat (VEC_WT[k]) @(negedge clk);
      busRead(4 + VEC_TMR[k], v);
      check($sformatf("R2 R1 R3 vector %0d", k), v, VEC_EXP[k]);
    end

    // R4: read clears, no completion on clearing edge
    startTimer(0, 1);
    repeat (8) @(negedge clk);
    busRead(4, v); check("R4 read value", v, 2);
    busRead(4, v2); check("R4 cleared after read", v2, 0);

    // R9: clear coincides with completion
    startTimer(0, 1);
    repeat (10) @(negedge clk);
    busRead(4, v); check("R9 read returns old", v, 2);
    busRead(4, v2); check("R9 counter ends at 1", v2, 1);

    // R8: other timers untouched while timer 0 runs
    busRead(5, v); check("R8 timer 1 idle", v, 0);

    // R5: write to counter address clears
    startTimer(1, 1);
    repeat (4) @(negedge clk);
    busWrite(5, 8'hAB);
    busRead(5, v); check("R5 write clears", v, 0);

    // R7: disabled timer holds its count
    startTimer(2, 1);
    repeat (5) @(negedge clk);
    busWrite(0, 0);
    repeat (20) @(negedge clk);
    busRead(6, v); check("R7 hold while disabled", v, 3);

    // R6: rising enable resets counter
    busWrite(6, 0);
    startTimer(2, 1);
    repeat (5) @(negedge clk);
    busWrite(0, 0);
    busWrite(0, 4);
    busRead(6, v); check("R6 rise resets", v, 0);

    // R6: rewriting an enabled bit as 1 does not restart
    startTimer(2, 1);
    repeat (5) @(negedge clk);
    busWrite(0, 4);
    busRead(6, v); check("R6 steady enable keeps count", v, 4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule